// File: doc/BRIEF.md
# Chip-Sequence Trigger and Sync Generator

This block steps a playback address through a fixed-length chip sequence, one step per chip-rate clock enable, and decides when that playback begins. In free-running mode the sequence starts right after reset and loops forever. In armed mode it waits for a trigger: either the chosen edge of an external trigger line, which is synchronized first, or a one-cycle software request. After an optional start delay counted in chips, playback begins. Once a trigger is accepted, further triggers are ignored for a programmable hold-off that is also counted in chips.

Alongside the address, the block keeps four frame counters that restart with the sequence. Each counter gives a one-chip pulse at the start of its period: traffic frame, short-code rollover (one third of the sequence), super frame (the full sequence) and even second. Two selectors route any two of these pulses to output pins. Every accepted trigger also produces a one-chip pulse on a trigger-out pin.

Top module: `chipseq_trig_sync`

## Requirements
- R1: While playing, `play_addr` advances by one on every chip enable and returns to 0 after `SEQ_LEN-1` (default 98304 chips). When not playing it reads 0.
- R2: When `chip_en` is low, the playback address and all frame counters hold their values, so every later sync pulse is delayed by the number of masked cycles.
- R3: With `cfg_auto`=1, playback starts on the first chip enable after reset and repeats without a break. External and software triggers are then ignored: they cause no trigger-out pulse and no restart.
- R4: With `cfg_auto`=0, a trigger is taken on the edge of `ext_trig` chosen by `cfg_edge_rising` (1 for rising, 0 for falling). The line passes through two flops, so with `chip_en` held high the trigger is accepted at the third clock edge after the line changes. The opposite edge is ignored.
- R5: After a trigger is accepted on some chip, playback restarts with address 0 on the chip `cfg_delay`+1 chips later. `playing` stays low until then.
- R6: After a trigger is accepted, triggers on the next `cfg_inhibit` chips are ignored. A trigger on the chip after that window is accepted.
- R7: A one-cycle `sw_trig` acts as a trigger edge and is accepted on the next chip enable.
- R8: Each accepted trigger raises `trig_out` for exactly one chip period, starting on the chip of acceptance.
- R9: Each sync pulse is high for one chip at the start of its period. All four pulses are high on the first chip of playback. The default periods are 24576, 32768, 98304 and 2457600 chips.
- R10: `sel_a` and `sel_b` each route one pulse to `sync_a` / `sync_b`, encoded as 0 = traffic frame, 1 = short-code rollover, 2 = super frame, 3 = even second.
- R11: Under reset, `playing`, `play_addr`, `trig_out`, `sync_a` and `sync_b` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip-rate clock enable |
| cfg_auto | input | 1 | 1 = free-running, 0 = armed |
| cfg_edge_rising | input | 1 | Active edge of the trigger line: 1 rising, 0 falling |
| cfg_delay | input | CNT_W | Start delay in chips |
| cfg_inhibit | input | CNT_W | Retrigger hold-off in chips |
| ext_trig | input | 1 | Asynchronous external trigger line |
| sw_trig | input | 1 | One-cycle software trigger request |
| sel_a | input | 2 | Pulse selected onto sync_a |
| sel_b | input | 2 | Pulse selected onto sync_b |
| play_addr | output | ADDR_W | Playback address |
| playing | output | 1 | Playback active |
| trig_out | output | 1 | Accepted-trigger pulse |
| sync_a | output | 1 | Selected sync pulse A |
| sync_b | output | 1 | Selected sync pulse B |

## Verification
With `chip_en` held high, an external edge driven in cycle c shows up on `trig_out` in cycle c+3, and address 0 with `playing` high appears in cycle c+4+delay. A software request in cycle x is accepted in x+1, and playback starts in x+2+delay. Sync pulses follow the start cycle by exact multiples of their periods, and they are pushed back by any masked `chip_en` cycles. The driver computes each due cycle from these offsets and puts it into the scoreboard. The monitor samples on the falling edge and compares only the items whose due cycle matches the current cycle count, so every result is checked in the cycle it first becomes valid, including the blocked and accepted triggers at both sides of the hold-off window.

// File: rtl/cst_pkg.sv
// Shared definitions for the chip-sequence trigger and sync generator.
package cst_pkg;
    localparam int NUM_SYNC = 4;

    // Pulse selector codes; order is visible at the sel_a/sel_b pins.
    typedef enum logic [1:0] {
        SEL_FRAME    = 2'd0,
        SEL_SHORT    = 2'd1,
        SEL_SUPER    = 2'd2,
        SEL_EVEN_SEC = 2'd3
    } sync_sel_e;

    // Largest of four period counts, used to size the frame counters.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/cst_trig_front.sv
// Trigger front end: synchronizes the external line, detects the configured
// edge, merges software requests, applies the retrigger hold-off and emits the
// accept strobe and the one-chip trigger-out pulse.
// Assumes ext_trig is asynchronous and sw_trig is a one-cycle pulse in clk.
module cst_trig_front #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             cfg_auto,
    input  logic             cfg_edge_rising,
    input  logic [CNT_W-1:0] cfg_inhibit,
    input  logic             ext_trig,
    input  logic             sw_trig,
    output logic             trig_acc,
    output logic             trig_out,
    output logic [CNT_W-1:0] inh_cnt
);
    logic meta_q, sync_q, level_q, sw_pend_q;
    logic edge_hit, trig_req;

    // Two-flop synchronizer for the asynchronous trigger line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= ext_trig;
            sync_q <= meta_q;
        end
    end

    // Level seen at the previous chip, reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)       level_q <= 1'b0;
        else if (chip_en) level_q <= sync_q;
    end

    // Holds a software request that arrives between chip enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_pend_q <= 1'b0;
        else if (chip_en) sw_pend_q <= 1'b0;
        else if (sw_trig) sw_pend_q <= 1'b1;
    end

    // Edge detection with selectable polarity and acceptance gating.
    always_comb begin
        edge_hit = cfg_edge_rising ? (sync_q & ~level_q) : (~sync_q & level_q);
        trig_req = chip_en & (edge_hit | sw_trig | sw_pend_q);
        trig_acc = trig_req & ~cfg_auto & (inh_cnt == '0);
    end

    // Retrigger hold-off counter, loaded on each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)                       inh_cnt <= '0;
        else if (trig_acc)                inh_cnt <= cfg_inhibit;
        else if (chip_en && inh_cnt != 0) inh_cnt <= inh_cnt - 1'b1;
    end

    // One-chip trigger-out pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_out <= 1'b0;
        else if (chip_en) trig_out <= trig_acc;
    end
endmodule

// File: rtl/cst_play_ctrl.sv
// Playback controller: counts the start delay after an accepted trigger,
// starts playback at address 0 and steps the address with wrap-around.
// Free-running mode starts playback whenever it is idle. Assumes trig_acc
// is asserted only on chip-enable cycles.
module cst_play_ctrl #(
    parameter int SEQ_LEN = 98304,
    parameter int CNT_W   = 16,
    localparam int ADDR_W = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              cfg_auto,
    input  logic [CNT_W-1:0]  cfg_delay,
    input  logic              trig_acc,
    output logic              start,
    output logic              playing,
    output logic [ADDR_W-1:0] play_addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SEQ_LEN - 1);

    logic             waiting_q;
    logic [CNT_W-1:0] dly_q;

    // Start condition: idle in auto mode, or delay expired in armed mode.
    always_comb begin
        start = chip_en & ~trig_acc &
                ((cfg_auto & ~playing) | (waiting_q & (dly_q == '0)));
    end

    // Delay countdown, playback state and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            dly_q     <= '0;
            playing   <= 1'b0;
            play_addr <= '0;
        end else if (trig_acc) begin
            waiting_q <= 1'b1;
            dly_q     <= cfg_delay;
            playing   <= 1'b0;
            play_addr <= '0;
        end else if (chip_en) begin
            if (start) begin
                waiting_q <= 1'b0;
                playing   <= 1'b1;
                play_addr <= '0;
            end else begin
                if (waiting_q) dly_q <= dly_q - 1'b1;
                if (playing)   play_addr <= (play_addr == LAST) ? '0 : play_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cst_sync_gen.sv
// Frame counters: one counter per system period. All counters restart with
// playback and advance on chip enables while playing. Each one flags the
// first chip of its period. Assumes every period is at least 2 chips.
module cst_sync_gen #(
    parameter int P_FRAME    = 24576,
    parameter int P_SHORT    = 32768,
    parameter int P_SUPER    = 98304,
    parameter int P_EVEN_SEC = 2457600,
    localparam int NS        = cst_pkg::NUM_SYNC,
    localparam int CW        = $clog2(cst_pkg::max4(P_FRAME, P_SHORT, P_SUPER, P_EVEN_SEC))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en,
    input  logic          start,
    input  logic          playing,
    output logic [NS-1:0] pulse
);
    for (genvar g = 0; g < NS; g++) begin : g_per
        localparam int PER = (g == 0) ? P_FRAME :
                             (g == 1) ? P_SHORT :
                             (g == 2) ? P_SUPER : P_EVEN_SEC;
        logic [CW-1:0] cnt_q;

        // Period counter aligned to playback start.
        always_ff @(posedge clk) begin
            if (!rst_n || start)         cnt_q <= '0;
            else if (chip_en && playing) cnt_q <= (cnt_q == CW'(PER - 1)) ? '0 : cnt_q + 1'b1;
        end

        assign pulse[g] = playing & (cnt_q == '0);
    end
endmodule

// File: rtl/chipseq_trig_sync.sv
// Top level: connects trigger front end, playback controller and frame
// counters, and routes two selected sync pulses to output pins.
// Assumes chip_en is a single-cycle-wide enable at chip rate.
module chipseq_trig_sync #(
    parameter int SEQ_LEN    = 98304,
    parameter int CNT_W      = 16,
    parameter int P_FRAME    = 24576,
    parameter int P_SHORT    = 32768,
    parameter int P_SUPER    = 98304,
    parameter int P_EVEN_SEC = 2457600,
    localparam int ADDR_W    = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              cfg_auto,
    input  logic              cfg_edge_rising,
    input  logic [CNT_W-1:0]  cfg_delay,
    input  logic [CNT_W-1:0]  cfg_inhibit,
    input  logic              ext_trig,
    input  logic              sw_trig,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    output logic [ADDR_W-1:0] play_addr,
    output logic              playing,
    output logic              trig_out,
    output logic              sync_a,
    output logic              sync_b
);
    logic                         trig_acc;
    logic                         start;
    logic [CNT_W-1:0]             inh_cnt;
    logic [cst_pkg::NUM_SYNC-1:0] sync_vec;

    cst_trig_front #(.CNT_W(CNT_W)) u_front (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_auto(cfg_auto),
        .cfg_edge_rising(cfg_edge_rising), .cfg_inhibit(cfg_inhibit),
        .ext_trig(ext_trig), .sw_trig(sw_trig),
        .trig_acc(trig_acc), .trig_out(trig_out), .inh_cnt(inh_cnt)
    );

    cst_play_ctrl #(.SEQ_LEN(SEQ_LEN), .CNT_W(CNT_W)) u_play (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_auto(cfg_auto),
        .cfg_delay(cfg_delay), .trig_acc(trig_acc),
        .start(start), .playing(playing), .play_addr(play_addr)
    );

    cst_sync_gen #(
        .P_FRAME(P_FRAME), .P_SHORT(P_SHORT),
        .P_SUPER(P_SUPER), .P_EVEN_SEC(P_EVEN_SEC)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start(start),
        .playing(playing), .pulse(sync_vec)
    );

    // Output routing of the two selected sync pulses.
    always_comb begin
        sync_a = sync_vec[sel_a];
        sync_b = sync_vec[sel_b];
    end
endmodule

// File: rtl/cst_checker.sv
// Property checker for chipseq_trig_sync, attached with bind below.
module cst_checker #(
    parameter int SEQ_LEN = 98304,
    parameter int CNT_W   = 16,
    localparam int ADDR_W = $clog2(SEQ_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              cfg_auto,
    input logic              playing,
    input logic [ADDR_W-1:0] play_addr,
    input logic              trig_out,
    input logic              trig_acc,
    input logic [CNT_W-1:0]  inh_cnt,
    input logic [3:0]        sync_vec
);
    // R1: address stays inside the sequence.
    p_addr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(play_addr) < SEQ_LEN);

    // R1: last chip is followed by address 0.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && playing && int'(play_addr) == SEQ_LEN - 1) |=> (play_addr == '0));

    // R1: idle address reads zero.
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !playing |-> (play_addr == '0));

    // R2: no advance without chip enable.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> $stable(play_addr));

    // R3: free-running mode never emits trigger-out.
    p_auto_no_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto && $past(cfg_auto)) |-> !trig_out);

    // R6: no acceptance while hold-off runs.
    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_cnt != '0) |-> !trig_acc);

    // R9: all pulses coincide at playback start.
    p_sync_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(playing) |-> (sync_vec == 4'b1111));
endmodule

bind chipseq_trig_sync cst_checker #(.SEQ_LEN(SEQ_LEN), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_auto(cfg_auto),
    .playing(playing), .play_addr(play_addr), .trig_out(trig_out),
    .trig_acc(trig_acc), .inh_cnt(inh_cnt), .sync_vec(sync_vec)
);

// File: tb/chipseq_trig_sync_test.sv
// Scoreboard bench: the driver pushes expected values with their due cycle,
// the monitor compares them on the falling edge of that cycle.
module chipseq_trig_sync_test;
    localparam int SEQ   = 96;
    localparam int CW    = 8;
    localparam int AW    = $clog2(SEQ);
    localparam int INHIB = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b1;
    logic          cfg_auto = 1'b0;
    logic          cfg_edge_rising = 1'b1;
    logic [CW-1:0] cfg_delay = '0;
    logic [CW-1:0] cfg_inhibit = CW'(INHIB);
    logic          ext_trig = 1'b0;
    logic          sw_trig = 1'b0;
    logic [1:0]    sel_a = cst_pkg::SEL_FRAME;
    logic [1:0]    sel_b = cst_pkg::SEL_SHORT;
    logic [AW-1:0] play_addr;
    logic          playing, trig_out, sync_a, sync_b;

    chipseq_trig_sync #(
        .SEQ_LEN(SEQ), .CNT_W(CW), .P_FRAME(24), .P_SHORT(32),
        .P_SUPER(96), .P_EVEN_SEC(2400)
    ) uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_auto(cfg_auto),
        .cfg_edge_rising(cfg_edge_rising), .cfg_delay(cfg_delay),
        .cfg_inhibit(cfg_inhibit), .ext_trig(ext_trig), .sw_trig(sw_trig),
        .sel_a(sel_a), .sel_b(sel_b), .play_addr(play_addr),
        .playing(playing), .trig_out(trig_out), .sync_a(sync_a), .sync_b(sync_b)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    due;
        int    sig;   // 0 addr, 1 playing, 2 trig_out, 3 sync_a, 4 sync_b
        int    val;
        string req;
    } exp_t;
    exp_t sb[$];

    function automatic int read_sig(int s);
        case (s)
            0:       return int'(play_addr);
            1:       return int'(playing);
            2:       return int'(trig_out);
            3:       return int'(sync_a);
            default: return int'(sync_b);
        endcase
    endfunction

    function automatic string sig_name(int s);
        case (s)
            0:       return "play_addr";
            1:       return "playing";
            2:       return "trig_out";
            3:       return "sync_a";
            default: return "sync_b";
        endcase
    endfunction

    task automatic push_exp(int due, int sig, int val, string req);
        exp_t e;
        e.due = due; e.sig = sig; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic check_now(int sig, int val, string req);
        int act;
        act = read_sig(sig);
        checks++;
        if (act != val) begin
            fails++;
            $display("FAIL %s cyc=%0d %s actual=%0d expected=%0d", req, cyc, sig_name(sig), act, val);
        end
    endtask

    // Monitor: pops every item due in the current cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                check_now(sb[i].sig, sb[i].val, sb[i].req);
                sb.delete(i);
            end
        end
    end

    task automatic wait_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic pulse_sw(int x);
        wait_to(x);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog cyc=%0d actual=timeout expected=done", cyc);
        finish_run();
    end

    initial begin
        int c, x, c2, c3, r;
        repeat (3) @(negedge clk);
        // R11: reset state
        check_now(1, 0, "R11");
        check_now(0, 0, "R11");
        check_now(2, 0, "R11");
        check_now(3, 0, "R11");
        check_now(4, 0, "R11");
        rst_n = 1'b1;

        // R4/R5/R8/R9/R10/R1: rising edge, zero delay
        c = cyc + 4;
        push_exp(c + 2, 2, 0, "R4");
        push_exp(c + 3, 2, 1, "R8");
        push_exp(c + 4, 2, 0, "R8");
        push_exp(c + 3, 1, 0, "R5");
        push_exp(c + 4, 1, 1, "R5");
        push_exp(c + 4, 0, 0, "R5");
        push_exp(c + 9, 0, 5, "R1");
        push_exp(c + 99, 0, 95, "R1");
        push_exp(c + 100, 0, 0, "R1");
        push_exp(c + 4, 3, 1, "R9");
        push_exp(c + 4, 4, 1, "R9");
        push_exp(c + 5, 3, 0, "R9");
        push_exp(c + 27, 3, 0, "R10");
        push_exp(c + 28, 3, 1, "R10");
        push_exp(c + 35, 4, 0, "R10");
        push_exp(c + 36, 4, 1, "R10");
        wait_to(c);
        ext_trig = 1'b1;

        // R7/R5/R6: software trigger with delay, then hold-off window
        x = c + 110;
        wait_to(x - 2);
        cfg_delay = CW'(7);
        push_exp(x + 1, 2, 1, "R7");
        push_exp(x + 1, 1, 0, "R8");
        push_exp(x + 8, 1, 0, "R5");
        push_exp(x + 9, 1, 1, "R5");
        push_exp(x + 9, 0, 0, "R5");
        push_exp(x + 11, 2, 0, "R6");
        push_exp(x + 11, 0, 2, "R6");
        push_exp(x + 12, 2, 1, "R6");
        push_exp(x + 12, 1, 0, "R6");
        push_exp(x + 19, 1, 0, "R5");
        push_exp(x + 20, 1, 1, "R5");
        push_exp(x + 20, 0, 0, "R5");
        pulse_sw(x);
        pulse_sw(x + 10);
        pulse_sw(x + 11);

        // R4: falling edge polarity, rising edge then ignored
        c2 = x + 40;
        wait_to(c2 - 2);
        cfg_delay = '0;
        cfg_edge_rising = 1'b0;
        push_exp(c2 + 3, 2, 1, "R4");
        push_exp(c2 + 4, 0, 0, "R4");
        push_exp(c2 + 4, 1, 1, "R4");
        c3 = c2 + 20;
        push_exp(c3 + 3, 2, 0, "R4");
        push_exp(c3 + 4, 2, 0, "R4");
        push_exp(c3 + 3, 0, 19, "R4");
        push_exp(c3 + 3, 1, 1, "R4");
        wait_to(c2);
        ext_trig = 1'b0;
        wait_to(c3);
        ext_trig = 1'b1;

        // R3: free-running mode from reset
        wait_to(c3 + 10);
        rst_n = 1'b0;
        cfg_auto = 1'b1;
        sel_a = cst_pkg::SEL_SUPER;
        sel_b = cst_pkg::SEL_EVEN_SEC;
        repeat (2) @(negedge clk);
        check_now(1, 0, "R11");
        r = cyc;
        rst_n = 1'b1;
        push_exp(r + 1, 1, 1, "R3");
        push_exp(r + 1, 0, 0, "R3");
        push_exp(r + 1, 3, 1, "R9");
        push_exp(r + 1, 4, 1, "R9");
        push_exp(r + 2, 3, 0, "R9");
        push_exp(r + 51, 2, 0, "R3");
        push_exp(r + 52, 0, 51, "R3");
        push_exp(r + 96, 3, 0, "R10");
        push_exp(r + 97, 3, 1, "R10");
        push_exp(r + 97, 4, 0, "R10");
        push_exp(r + 97, 0, 0, "R1");
        // R2: three masked chip enables shift everything by 3
        push_exp(r + 200, 0, 199 % SEQ, "R2");
        push_exp(r + 203, 0, 199 % SEQ, "R2");
        push_exp(r + 204, 0, 200 % SEQ, "R2");
        push_exp(r + 2403, 4, 0, "R2");
        push_exp(r + 2404, 4, 1, "R2");
        pulse_sw(r + 50);
        wait_to(r + 200);
        chip_en = 1'b0;
        wait_to(r + 203);
        chip_en = 1'b1;
        wait_to(r + 2410);
        finish_run();
    end
endmodule